// File: doc/BRIEF.md
# SHA-3 Vector Helper Execution Unit

This unit decodes one 32-bit instruction word per cycle and executes the four vector helper operations used to build the Keccak round: a three-way XOR, a bit-clear-and-XOR, an XOR followed by a rotate right by an immediate, and an XOR with an operand rotated left by one. Each operation works on a 128-bit vector treated as two independent 64-bit lanes.

Source register indices are decoded from the word and driven to three register-file read ports. The surrounding logic returns the operand data in the same cycle. One clock after the instruction is offered, the unit reports one of three outcomes: a 128-bit result with its destination index, an undefined-instruction flag, or an access-trap flag. A feature-enable input and a vector-access-enable input gate execution. The feature check comes first, and the access check is made only after it passes.

Top module: `sha3_vec_unit`

## Requirements
- R1: A word with (insn & 0xFF808000) == 0xCE000000 is a four-operand word with fields sel = bits[22:21], second source = bits[20:16], third source = bits[14:10], first source = bits[9:5] and destination = bits[4:0]. With sel = 0, each lane of the result is first XOR second XOR third.
- R2: A four-operand word with sel = 1 yields, in each lane, first XOR (second AND NOT third).
- R3: A four-operand word with sel = 2 or sel = 3 raises the undefined flag and writes no result.
- R4: A word with (insn & 0xFFE00000) == 0xCE800000 takes its second source from bits[20:16], a rotate amount from bits[15:10], its first source from bits[9:5] and its destination from bits[4:0]. In each lane it yields (first XOR second) rotated right by that amount, for every amount from 0 to 63.
- R5: A word with (insn & 0xFFE0B000) == 0xCE608000, bit 14 = 0 and bits[11:10] = 3 yields, in each lane, first XOR (second rotated left by 1). The fields are the same as in R4 except the rotate amount. Any other value of bits[11:10], or bit 14 = 1, raises the undefined flag.
- R6: Lane 0 (bits 63:0) and lane 1 (bits 127:64) are computed independently, and both lanes of the destination are written.
- R7: While the feature-enable input is low, every word raises the undefined flag and produces no result, whatever the access-enable input is.
- R8: With the feature enabled and the access-enable input low, a valid recognised word raises the trap flag and produces no result.
- R9: Result, destination, result-valid and both flags are registered one clock after the input strobe. At most one of result-valid, undefined and trap is high. All three are low in a cycle that follows a cycle with no input strobe.
- R10: A word that matches none of the three groups raises the undefined flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word strobe |
| insn | input | 32 | Instruction word |
| feat_en | input | 1 | SHA-3 feature enable |
| simd_en | input | 1 | Vector register access enable |
| src_a_idx | output | 5 | Read index for the first source |
| src_b_idx | output | 5 | Read index for the second source |
| src_c_idx | output | 5 | Read index for the third source |
| src_a_data | input | 128 | First source data, same cycle |
| src_b_data | input | 128 | Second source data, same cycle |
| src_c_data | input | 128 | Third source data, same cycle |
| res_valid | output | 1 | Result and destination are valid |
| res_data | output | 128 | Result vector |
| res_dst | output | 5 | Destination register index |
| undef_flag | output | 1 | Undefined-instruction outcome |
| trap_flag | output | 1 | Access-trap outcome |

## Verification
Every outcome (result, destination and either flag) is due at the first rising edge after the word is presented. The bench applies each word at a falling edge and compares all five outputs at the next falling edge, half a period after that registering edge. A single idle cycle is then issued and checked, to show that the outputs drop with no strobe. The bench computes expected lanes itself with bit-by-bit rotations over a register file filled with arithmetic patterns. It covers every rotate amount and every value of the select and opcode fields.

// File: rtl/sha3_pkg.sv
package sha3_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned ROT_W  = 6;

  typedef enum logic [1:0] {
    OP_XOR3  = 2'd0,
    OP_BCLR  = 2'd1,
    OP_XROT  = 2'd2,
    OP_RLXOR = 2'd3
  } sha3_op_e;

  typedef struct packed {
    logic              known;
    sha3_op_e          op;
    logic [REG_AW-1:0] src_a;
    logic [REG_AW-1:0] src_b;
    logic [REG_AW-1:0] src_c;
    logic [REG_AW-1:0] dst;
    logic [ROT_W-1:0]  rot;
  } sha3_dec_t;
endpackage

// File: rtl/sha3_decode.sv
module sha3_decode
  import sha3_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output sha3_dec_t         dec
);
  logic grp4, grpx, grp3;

  always_comb begin
    grp4 = (insn & 32'hFF80_8000) == 32'hCE00_0000;
    grpx = (insn & 32'hFFE0_0000) == 32'hCE80_0000;
    grp3 = (insn & 32'hFFE0_B000) == 32'hCE60_8000;

    dec.src_a = insn[9:5];
    dec.src_b = insn[20:16];
    dec.src_c = insn[14:10];
    dec.dst   = insn[4:0];
    dec.rot   = insn[15:10];
    dec.op    = OP_XOR3;
    dec.known = 1'b0;

    if (grp4) begin
      if (insn[22:21] == 2'd0) begin
        dec.op    = OP_XOR3;
        dec.known = 1'b1;
      end else if (insn[22:21] == 2'd1) begin
        dec.op    = OP_BCLR;
        dec.known = 1'b1;
      end
    end else if (grpx) begin
      dec.op    = OP_XROT;
      dec.known = 1'b1;
    end else if (grp3) begin
      if (!insn[14] && insn[11:10] == 2'd3) begin
        dec.op    = OP_RLXOR;
        dec.known = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sha3_lane.sv
module sha3_lane
  import sha3_pkg::*;
#(
  parameter int unsigned LANE_W = 64,
  parameter int unsigned RW     = 6
) (
  input  sha3_op_e          op,
  input  logic [RW-1:0]     rot,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic [LANE_W-1:0] c,
  output logic [LANE_W-1:0] y
);
  logic [LANE_W-1:0]   mix;
  logic [2*LANE_W-1:0] dbl;
  logic [LANE_W-1:0]   b_rl1;

  always_comb begin
    mix   = a ^ b;
    dbl   = {mix, mix} >> rot;
    b_rl1 = {b[LANE_W-2:0], b[LANE_W-1]};
    unique case (op)
      OP_XOR3:  y = mix ^ c;
      OP_BCLR:  y = a ^ (b & ~c);
      OP_XROT:  y = dbl[LANE_W-1:0];
      OP_RLXOR: y = a ^ b_rl1;
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/sha3_vec_unit.sv
module sha3_vec_unit
  import sha3_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      insn_valid,
  input  logic [31:0]               insn,
  input  logic                      feat_en,
  input  logic                      simd_en,
  output logic [4:0]                src_a_idx,
  output logic [4:0]                src_b_idx,
  output logic [4:0]                src_c_idx,
  input  logic [LANES*LANE_W-1:0]   src_a_data,
  input  logic [LANES*LANE_W-1:0]   src_b_data,
  input  logic [LANES*LANE_W-1:0]   src_c_data,
  output logic                      res_valid,
  output logic [LANES*LANE_W-1:0]   res_data,
  output logic [4:0]                res_dst,
  output logic                      undef_flag,
  output logic                      trap_flag
);
  localparam int unsigned VEC_W = LANES * LANE_W;

  sha3_dec_t        dec;
  logic [VEC_W-1:0] alu_y;
  logic             ok_nx, und_nx, trp_nx, data_en;

  sha3_decode u_dec (.insn(insn), .dec(dec));

  assign src_a_idx = dec.src_a;
  assign src_b_idx = dec.src_b;
  assign src_c_idx = dec.src_c;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sha3_lane #(.LANE_W(LANE_W), .RW(ROT_W)) u_lane (
      .op (dec.op),
      .rot(dec.rot),
      .a  (src_a_data[g*LANE_W +: LANE_W]),
      .b  (src_b_data[g*LANE_W +: LANE_W]),
      .c  (src_c_data[g*LANE_W +: LANE_W]),
      .y  (alu_y[g*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    und_nx  = insn_valid && (!dec.known || !feat_en);
    trp_nx  = insn_valid && dec.known && feat_en && !simd_en;
    ok_nx   = insn_valid && dec.known && feat_en && simd_en;
    data_en = ok_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      undef_flag <= 1'b0;
      trap_flag  <= 1'b0;
    end else begin
      res_valid  <= ok_nx;
      undef_flag <= und_nx;
      trap_flag  <= trp_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data <= '0;
      res_dst  <= '0;
    end else if (data_en) begin
      res_data <= alu_y;
      res_dst  <= dec.dst;
    end
  end

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_valid, undef_flag, trap_flag}));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> !res_valid && !undef_flag && !trap_flag);
  p_feat_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && !feat_en |=> undef_flag && !res_valid);
  p_access_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && feat_en && !simd_en |=> !res_valid);
  p_dst_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(res_dst) || res_valid);
endmodule

// File: tb/tb_sha3_vec_unit.sv
module tb_sha3_vec_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk, rst_n, insn_valid, feat_en, simd_en;
  logic [31:0]  insn;
  logic [4:0]   ia, ib, ic, res_dst;
  logic [127:0] da, db, dc, res_data;
  logic         res_valid, undef_flag, trap_flag;
  logic [127:0] rf [32];
  int checks, errors;

  sha3_vec_unit dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .feat_en(feat_en), .simd_en(simd_en),
    .src_a_idx(ia), .src_b_idx(ib), .src_c_idx(ic),
    .src_a_data(da), .src_b_data(db), .src_c_data(dc),
    .res_valid(res_valid), .res_data(res_data), .res_dst(res_dst),
    .undef_flag(undef_flag), .trap_flag(trap_flag)
  );

  assign da = rf[ia];
  assign db = rf[ib];
  assign dc = rf[ic];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] rotr(input logic [63:0] x, input int s);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = x[(i + s) % 64];
    return r;
  endfunction

  task automatic check(input string req, input logic v, input logic u, input logic t,
                       input logic [127:0] d, input logic [4:0] dst);
    checks++;
    if (res_valid !== v || undef_flag !== u || trap_flag !== t ||
        (v && (res_data !== d || res_dst !== dst))) begin
      errors++;
      $display("FAIL %s: got v=%b u=%b t=%b d=%h dst=%0d, expected v=%b u=%b t=%b d=%h dst=%0d",
               req, res_valid, undef_flag, trap_flag, res_data, res_dst, v, u, t, d, dst);
    end
  endtask

  // present a word at a falling edge, check at the next falling edge
  task automatic issue(input logic [31:0] w, input string req, input logic v, input logic u,
                       input logic t, input logic [127:0] d, input logic [4:0] dst);
    insn = w; insn_valid = 1'b1;
    @(negedge clk);
    check(req, v, u, t, d, dst);
    insn_valid = 1'b0;
  endtask

  task automatic idle(input string req);
    insn_valid = 1'b0; insn = 32'hCE00_0000;
    @(negedge clk);
    check(req, 1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  function automatic logic [31:0] enc4(int sel, int m, int a, int n, int d);
    return 32'hCE00_0000 | (sel << 21) | (m << 16) | (a << 10) | (n << 5) | d;
  endfunction
  function automatic logic [31:0] encx(int m, int r, int n, int d);
    return 32'hCE80_0000 | (m << 16) | (r << 10) | (n << 5) | d;
  endfunction
  function automatic logic [31:0] enc3(int opc, int m, int n, int d);
    return 32'hCE60_8000 | (m << 16) | (opc << 10) | (n << 5) | d;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] e;
    checks = 0; errors = 0;
    for (int i = 0; i < 32; i++)
      rf[i] = {64'hC2B2AE3D27D4EB4F * 64'(i + 3) ^ 64'(i),
               64'h9E3779B97F4A7C15 * 64'(i + 1)};
    rst_n = 1'b0; insn_valid = 1'b0; insn = '0; feat_en = 1'b1; simd_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset", 1'b0, 1'b0, 1'b0, '0, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R2, R6: three-way xor and bit-clear xor over register triples
    for (int k = 0; k < 32; k++) begin
      int n, m, a, d;
      n = k; m = (k * 7 + 3) % 32; a = (k * 13 + 5) % 32; d = 31 - k;
      for (int h = 0; h < 2; h++)
        e[h*64 +: 64] = rf[n][h*64 +: 64] ^ rf[m][h*64 +: 64] ^ rf[a][h*64 +: 64];
      issue(enc4(0, m, a, n, d), "R1 R6 xor3", 1, 0, 0, e, 5'(d));
      for (int h = 0; h < 2; h++)
        e[h*64 +: 64] = rf[n][h*64 +: 64] ^ (rf[m][h*64 +: 64] & ~rf[a][h*64 +: 64]);
      issue(enc4(1, m, a, n, d), "R2 R6 bclr", 1, 0, 0, e, 5'(d));
    end
    idle("R9 idle after stream");

    // R3: reserved selector values
    issue(enc4(2, 1, 2, 3, 4), "R3 sel2", 0, 1, 0, '0, '0);
    issue(enc4(3, 1, 2, 3, 4), "R3 sel3", 0, 1, 0, '0, '0);

    // R4: every rotate amount
    for (int r = 0; r < 64; r++) begin
      int n, m, d;
      n = (r * 5) % 32; m = (r * 11 + 1) % 32; d = r % 32;
      for (int h = 0; h < 2; h++)
        e[h*64 +: 64] = rotr(rf[n][h*64 +: 64] ^ rf[m][h*64 +: 64], r);
      issue(encx(m, r, n, d), "R4 R6 xor-rotr", 1, 0, 0, e, 5'(d));
    end

    // R5: rotate-left-one xor, plus the other opcodes and bit 14
    for (int k = 0; k < 16; k++) begin
      int n, m, d;
      n = (k * 3 + 2) % 32; m = (k * 9 + 7) % 32; d = (k * 5) % 32;
      for (int h = 0; h < 2; h++)
        e[h*64 +: 64] = rf[n][h*64 +: 64] ^ rotr(rf[m][h*64 +: 64], 63);
      issue(enc3(3, m, n, d), "R5 R6 rl1xor", 1, 0, 0, e, 5'(d));
    end
    for (int o = 0; o < 3; o++)
      issue(enc3(o, 4, 5, 6), "R5 other opcode", 0, 1, 0, '0, '0);
    issue(enc3(3, 4, 5, 6) | 32'h0000_4000, "R5 bit14 set", 0, 1, 0, '0, '0);

    // R10: unmatched words
    issue(32'h0000_0000, "R10 zero word", 0, 1, 0, '0, '0);
    issue(enc4(0, 1, 2, 3, 4) | 32'h0000_8000, "R10 bit15 in four-op", 0, 1, 0, '0, '0);
    issue(32'hCEC0_8000, "R10 near miss", 0, 1, 0, '0, '0);

    // R7: feature off, with access on and off
    feat_en = 1'b0;
    for (int s = 0; s < 2; s++) begin
      simd_en = s[0];
      issue(enc4(0, 1, 2, 3, 4), "R7 xor3", 0, 1, 0, '0, '0);
      issue(encx(1, 9, 3, 4), "R7 xrot", 0, 1, 0, '0, '0);
      issue(enc3(3, 1, 3, 4), "R7 rl1xor", 0, 1, 0, '0, '0);
    end
    // R8: access off
    feat_en = 1'b1; simd_en = 1'b0;
    issue(enc4(1, 1, 2, 3, 4), "R8 bclr", 0, 0, 1, '0, '0);
    issue(encx(1, 9, 3, 4), "R8 xrot", 0, 0, 1, '0, '0);
    issue(enc3(3, 1, 3, 4), "R8 rl1xor", 0, 0, 1, '0, '0);
    issue(enc4(2, 1, 2, 3, 4), "R8 undef wins", 0, 1, 0, '0, '0);
    simd_en = 1'b1;
    idle("R9 idle final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule